// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block passes short messages between an application processor and an I/O co-processor through two independent queues. The outbound queue carries traffic from the application side to the I/O side, and the inbound queue carries traffic the other way. Each message has two parts: a 64-bit first word and a 32-bit second word. Both processors reach the block over one shared register bus. Each queue has a control register, two send registers and two receive registers.

A sender first writes the first word, which only stages it. It then writes the second word, which commits both words as one queue entry. A receiver may read the first word as often as it likes without changing anything. Reading the second word removes the head entry. That read also returns live pointer and occupancy fields in the upper bits. The bus never applies back-pressure. Every access completes in the cycle it is presented, and read data is combinational in that cycle. Flow control is left to software: a sender checks the full flag before pushing, and a receiver checks the empty flag before popping. If a sender ignores the full flag, its push is lost and the loss is recorded in a sticky overflow flag.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty: each control register reads bit 17 (empty) = 1, bit 16 (full) = 0 and bit 18 (overflow) = 0, and every other bit reads 0.
- R2: A write to the first send word (queue base + 0x10) only stages data and leaves the queue empty. A write to the second send word (base + 0x18) commits the staged word and bits 31:0 of the written data as one entry. Bits 63:32 of that second write are ignored.
- R3: Entries leave a queue in the order they were committed, and each pop lowers the occupancy by one.
- R4: Control bit 16 is 1 exactly when the queue holds DEPTH entries. Control bit 17 is 1 exactly when it holds none.
- R5: A commit while the queue is full is dropped and leaves the stored entries unchanged. It also sets control bit 18.
- R6: Control bit 18 stays set until a control-register write with bit 18 = 1 clears it. A control write with bit 18 = 0 leaves it unchanged.
- R7: A read of the first receive word (base + 0x20) returns the head entry's first word and does not remove the entry.
- R8: A read of the second receive word (base + 0x28) returns the following fields and removes the head entry:
  - bits 31:0: the head entry's second word;
  - bits 56:52: the occupancy, saturated at 31;
  - bits 51:48: the occupancy, saturated at 15;
  - bits 47:44: the write pointer, modulo 16;
  - bits 43:40: the read pointer, modulo 16.
  All fields are taken before the pop, and all other bits read 0.
- R9: Reading either receive word of an empty queue returns 0 in the data bits and leaves the pointers and occupancy unchanged.
- R10: The outbound queue is based at 0x50 and the inbound queue at 0x80. Traffic on one queue never changes the other.
- R11: The write and read pointers wrap from DEPTH-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe. It takes precedence over bus_rd in the same cycle. |
| bus_rd | input | 1 | Read strobe. Receive-word reads with side effects take effect at the clock edge. |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid in the cycle bus_rd is high; 0 for unmapped addresses |

## Verification
The bench exercises the main push/pop path with several kinds of traffic, and each kind exposes a different class of fault.
- A single staged-then-committed entry shows whether staging is kept apart from committing, and whether the upper bits of the second send word leak into the entry.
- Two back-to-back entries, each peeked repeatedly and then popped, separate a side-effect-free peek from a pop. They also check the pointer and count fields against values worked out by hand.
- A fill to capacity followed by one extra commit and a full drain, started from a non-zero pointer, covers the full flag, the dropped write, the sticky overflow flag and its clear rule, and pointer wrap-around.
- Traffic aimed at only one queue, with the other queue's control register checked alongside, catches decode that aliases the two queues.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int MSG0_W   = 64;
  localparam int MSG1_W   = 32;
  localparam int BUS_AW   = 8;
  localparam int BUS_DW   = 64;
  localparam int NUM_FIFO = 2;

  // register offsets relative to a queue base
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_SEND0 = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_SEND1 = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_RECV0 = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_RECV1 = 8'h28;

  // control register bits
  localparam int BIT_FULL  = 16;
  localparam int BIT_EMPTY = 17;
  localparam int BIT_OVF   = 18;

  // queue 0 is outbound (app to I/O), queue 1 is inbound
  function automatic logic [BUS_AW-1:0] fifo_base(input int idx);
    return (idx == 0) ? 8'h50 : 8'h80;
  endfunction

  // upper status fields of the second receive word
  function automatic logic [BUS_DW-1:0] status_bits(input logic [31:0] occ,
                                                    input logic [3:0]  wptr,
                                                    input logic [3:0]  rptr);
    logic [4:0] c5;
    logic [3:0] c4;
    c5 = (occ > 32'd31) ? 5'd31 : occ[4:0];
    c4 = (occ > 32'd15) ? 4'd15 : occ[3:0];
    status_bits = '0;
    status_bits[56:52] = c5;
    status_bits[51:48] = c4;
    status_bits[47:44] = wptr;
    status_bits[43:40] = rptr;
  endfunction

  typedef struct packed {
    logic ctrl_rd;
    logic ctrl_wr;
    logic stage;
    logic push;
    logic peek;
    logic pop;
  } mbox_sel_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int NF = NUM_FIFO
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output mbox_sel_t         sel [NF]
);

  logic rd_only;
  assign rd_only = rd && !wr;

  for (genvar i = 0; i < NF; i++) begin : g_dec
    logic [BUS_AW-1:0] base;
    assign base = fifo_base(i);
    assign sel[i] = '{
      ctrl_rd: rd_only && (addr == base + OFS_CTRL),
      ctrl_wr: wr      && (addr == base + OFS_CTRL),
      stage:   wr      && (addr == base + OFS_SEND0),
      push:    wr      && (addr == base + OFS_SEND1),
      peek:    rd_only && (addr == base + OFS_RECV0),
      pop:     rd_only && (addr == base + OFS_RECV1)
    };
  end

endmodule

// File: rtl/mbox_fifo.sv
module mbox_fifo
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_we,
  input  logic              push_we,
  input  logic              pop_re,
  input  logic              ovf_clr,
  input  logic [BUS_DW-1:0] wdata,
  output logic [MSG0_W-1:0] head0,
  output logic [MSG1_W-1:0] head1,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic [PW-1:0]     wr_ptr,
  output logic [PW-1:0]     rd_ptr,
  output logic [CW-1:0]     count
);

  logic [MSG0_W-1:0] mem0 [DEPTH];
  logic [MSG1_W-1:0] mem1 [DEPTH];
  logic [MSG0_W-1:0] staged;
  logic push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_we && !full;
  assign pop_ok  = pop_re && !empty;
  assign head0   = empty ? '0 : mem0[rd_ptr];
  assign head1   = empty ? '0 : mem1[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem0[wr_ptr] <= staged;
      mem1[wr_ptr] <= wdata[MSG1_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (stage_we) staged <= wdata;
      if (push_ok)  wr_ptr <= nxt(wr_ptr);
      if (pop_ok)   rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
      if (push_we && full) ovf <= 1'b1;
      else if (ovf_clr)    ovf <= 1'b0;
    end
  end

  a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    stage_we && !push_we && !pop_re |=> count == $past(count));
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push_we && !full && !pop_re |=> count == $past(count) + CW'(1));
  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    pop_re && !empty && !push_we |=> count + CW'(1) == $past(count));
  a_r5_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    push_we && full |=> count == $past(count) && ovf);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  a_r9_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pop_re && empty && !push_we |=> rd_ptr == $past(rd_ptr) && empty);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  mbox_sel_t         sel     [NUM_FIFO];
  logic [BUS_DW-1:0] rv_ctrl [NUM_FIFO];
  logic [BUS_DW-1:0] rv_r0   [NUM_FIFO];
  logic [BUS_DW-1:0] rv_r1   [NUM_FIFO];

  mbox_decode #(.NF(NUM_FIFO)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .sel  (sel)
  );

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_q
    logic              full, empty, ovf;
    logic [MSG0_W-1:0] h0;
    logic [MSG1_W-1:0] h1;
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;

    mbox_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_we (sel[i].stage),
      .push_we  (sel[i].push),
      .pop_re   (sel[i].pop),
      .ovf_clr  (sel[i].ctrl_wr && bus_wdata[BIT_OVF]),
      .wdata    (bus_wdata),
      .head0    (h0),
      .head1    (h1),
      .full     (full),
      .empty    (empty),
      .ovf      (ovf),
      .wr_ptr   (wp),
      .rd_ptr   (rp),
      .count    (cnt)
    );

    assign rv_ctrl[i] = {45'd0, ovf, empty, full, 16'd0};
    assign rv_r0[i]   = h0;
    assign rv_r1[i]   = status_bits(32'(cnt), 4'(wp), 4'(rp)) | {32'd0, h1};

    a_r4_full_reports: assert property (@(posedge clk) disable iff (!rst_n)
      sel[i].ctrl_rd |-> bus_rdata[BIT_FULL] == (cnt == CW'(DEPTH)));
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_FIFO; i++) begin
      if (sel[i].ctrl_rd) bus_rdata |= rv_ctrl[i];
      if (sel[i].peek)    bus_rdata |= rv_r0[i];
      if (sel[i].pop)     bus_rdata |= rv_r1[i];
    end
  end

endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ipc_mailbox #(.DEPTH(8)) i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h50, 64'h0, 64'h0000_0000_0002_0000, 4'd1},  // R1 outbound empty
    '{1'b1, 8'h80, 64'h0, 64'h0000_0000_0002_0000, 4'd1},  // R1 inbound empty
    '{1'b0, 8'h60, 64'h1111_2222_3333_4444, 64'h0, 4'd2},
    '{1'b1, 8'h50, 64'h0, 64'h0000_0000_0002_0000, 4'd2},  // R2 staging only
    '{1'b0, 8'h68, 64'hFFFF_0000_AAAA_0001, 64'h0, 4'd2},
    '{1'b1, 8'h50, 64'h0, 64'h0, 4'd4},                    // R4 neither flag
    '{1'b0, 8'h60, 64'h5555_6666_7777_8888, 64'h0, 4'd3},
    '{1'b0, 8'h68, 64'h0000_0000_BBBB_0002, 64'h0, 4'd3},
    '{1'b1, 8'h70, 64'h0, 64'h1111_2222_3333_4444, 4'd7},  // R7 peek
    '{1'b1, 8'h70, 64'h0, 64'h1111_2222_3333_4444, 4'd7},  // R7 peek again
    '{1'b1, 8'h78, 64'h0, 64'h0022_2000_AAAA_0001, 4'd8},  // R8 fields + pop
    '{1'b1, 8'h70, 64'h0, 64'h5555_6666_7777_8888, 4'd3},  // R3 order
    '{1'b1, 8'h78, 64'h0, 64'h0011_2100_BBBB_0002, 4'd3},  // R3 second pop
    '{1'b1, 8'h50, 64'h0, 64'h0000_0000_0002_0000, 4'd4},  // R4 empty again
    '{1'b1, 8'h70, 64'h0, 64'h0, 4'd9},                    // R9 empty peek
    '{1'b1, 8'h78, 64'h0, 64'h0000_2200_0000_0000, 4'd9},  // R9 empty pop
    '{1'b1, 8'h50, 64'h0, 64'h0000_0000_0002_0000, 4'd9}   // R9 still empty
  };

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [63:0] rv;
    logic [63:0] e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].is_rd) begin
        bus_read(VECS[v].addr, rv);
        check(rv, VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
      end else begin
        bus_write(VECS[v].addr, VECS[v].data);
      end
    end

    // R10: inbound traffic leaves the outbound queue alone
    bus_write(8'h90, 64'h0123_4567_89AB_CDEF);
    bus_write(8'h98, 64'h0000_0000_CAFE_F00D);
    bus_read(8'h50, rv); check(rv, 64'h2_0000, "R10 outbound untouched");
    bus_read(8'h80, rv); check(rv, 64'h0, "R10 inbound holds one");
    bus_read(8'hA0, rv); check(rv, 64'h0123_4567_89AB_CDEF, "R10 inbound word0");
    bus_read(8'hA8, rv); check(rv, 64'h0011_1000_CAFE_F00D, "R10 inbound word1");

    // R4/R5: fill outbound from pointer 2 to capacity
    for (int i = 0; i < 8; i++) begin
      bus_write(8'h60, 64'h100 + 64'(i));
      bus_write(8'h68, 64'(i + 16));
    end
    bus_read(8'h50, rv); check(rv, 64'h1_0000, "R4 full flag");
    bus_write(8'h60, 64'hDEAD);
    bus_write(8'h68, 64'hDEAD);
    bus_read(8'h50, rv); check(rv, 64'h5_0000, "R5 overflow sticky set");
    // R6: clear rule
    bus_write(8'h50, 64'h0);
    bus_read(8'h50, rv); check(rv, 64'h5_0000, "R6 write without bit18 keeps flag");
    bus_write(8'h50, 64'h4_0000);
    bus_read(8'h50, rv); check(rv, 64'h1_0000, "R6 write bit18 clears flag");
    bus_read(8'h80, rv); check(rv, 64'h2_0000, "R10 inbound unaffected");

    // R11: drain across the pointer wrap
    for (int i = 0; i < 8; i++) begin
      bus_read(8'h70, rv);
      check(rv, 64'h100 + 64'(i), $sformatf("R3 drain word0 %0d", i));
      e = (64'(8 - i) << 52) | (64'(8 - i) << 48) | (64'd2 << 44)
        | (64'((2 + i) % 8) << 40) | 64'(i + 16);
      bus_read(8'h78, rv);
      check(rv, e, $sformatf("R11 drain word1 %0d", i));
    end
    bus_read(8'h50, rv); check(rv, 64'h2_0000, "R5 drained, nothing extra");
    bus_read(8'h78, rv); check(rv, 64'h0000_2200_0000_0000, "R11 pointers wrapped to 2");

    // R1: reset returns everything to empty
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(8'h50, rv); check(rv, 64'h2_0000, "R1 outbound after reset");
    bus_read(8'h78, rv); check(rv, 64'h0, "R1 outbound pointers after reset");

    report();
  end

endmodule